// File: doc/BRIEF.md
# Cascadable Serial Sample Output Port

This block hands finished I/Q sample words from a core clock domain to a host that reads them one bit at a time. The core presents a word pair with a one-cycle load strobe. The port keeps a copy and raises a short data-valid pulse that the host can use as an interrupt. The host runs its own serial clock, which need not be related to the core clock. When the host, or the port ahead of this one in a chain, raises frame sync, the port shifts the word out most significant bit first. A frame-end flag marks the last bit of the frame.

Each port drives its data pin low outside a frame. Because of this, the data pins of several ports can be ORed onto one host line. The frame-end output of one port is wired to the frame-sync input of the next. The whole chain then reads out back to back with a single sync pulse from the host. The port also watches how the host uses it. It flags a one-clock gap between frames, a word that is replaced before it was read, and a frame that is requested when no word is waiting.

Top module: `sop_serial_out`

## Requirements
- R1: After reset, sdata_out, frame_end, data_valid, overrun, gap_err and underrun are all low.
- R2: The first rising ser_clk edge that samples fsync_in high while the port is idle drives the frame's first bit onto sdata_out. Each later rising edge drives the next bit. In single mode the frame is the top W bits of word_i, most significant bit first, where W = 8*(len_sel+1): len_sel 0→8, 1→16, 2→24, 3→32.
- R3: data_valid is high for exactly 2 core_clk cycles after a load when dual_mode=0, and for exactly 4 when dual_mode=1. It starts in the cycle after the core_clk edge that samples load.
- R4: With dual_mode=1 the frame is 2W bits long: the top W bits of word_i first, then the top W bits of word_q, each most significant bit first.
- R5: frame_end is high for exactly the ser_clk period in which the last bit of a frame is on sdata_out, and low at all other times.
- R6: If fsync_in is high at the rising edge that ends the last bit, the next frame's first bit follows with no idle period, and gap_err stays low.
- R7: A frame sync that arrives exactly one ser_clk period after a frame ended sets gap_err, which then stays high until reset. An idle gap of two or more periods leaves gap_err low.
- R8: fsync_in is ignored while a frame is shifting, except at the edge that ends the last bit; the frame content is unaffected.
- R9: sdata_out is low whenever no frame is being shifted.
- R10: A second load before the first word was sent sets overrun, which stays high until reset. The next frame carries the newer word.
- R11: A frame requested with no word waiting shifts out all zeros and sets underrun, which stays high until reset.
- R12: With one port's frame_end driving a second port's fsync_in and their sdata_out ORed, a single sync pulse reads the first port's frame and then the second port's frame, bit for bit contiguous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core domain reset, active low, asynchronous |
| load | input | 1 | One-cycle strobe: capture word_i and word_q |
| word_i | input | 32 | I sample word, most significant bits are sent |
| word_q | input | 32 | Q sample word, sent in dual mode only |
| dual_mode | input | 1 | 1: frame carries I then Q; 0: I only (static) |
| len_sel | input | 2 | Word length select, W = 8*(len_sel+1) (static) |
| data_valid | output | 1 | New-word pulse, 2 or 4 core cycles |
| overrun | output | 1 | Sticky: word replaced before it was read |
| ser_clk | input | 1 | Host serial clock, asynchronous to core_clk |
| ser_rst_n | input | 1 | Serial domain reset, active low, asynchronous |
| fsync_in | input | 1 | Frame sync from host or upstream frame_end |
| sdata_out | output | 1 | Serial data, low when idle |
| frame_end | output | 1 | High during the last bit of a frame |
| gap_err | output | 1 | Sticky: one-period gap between frames seen |
| underrun | output | 1 | Sticky: frame requested with no word pending |

## Verification
The assertions assume that dual_mode and len_sel are held constant while the port runs. They also assume that loads come far enough apart for the request toggle to cross into the serial domain and for the serial side to copy the word before it changes. The bench changes the configuration only between scenarios. After every load it waits several serial clocks before it asks for a frame or loads again. The bench changes fsync_in and load only on falling clock edges and reads sdata_out on falling serial edges, the way a host would. This keeps every input stable around the rising edges the assertions sample.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        WLEN_8  = 2'd0,
        WLEN_16 = 2'd1,
        WLEN_24 = 2'd2,
        WLEN_32 = 2'd3
    } wlen_e;

    // bits per word for a length select, in steps of a quarter word
    function automatic int unsigned word_len(input logic [1:0] sel, input int unsigned dw);
        return (int'(sel) + 1) * (dw / 4);
    endfunction

endpackage

// File: rtl/sop_sync.sv
module sop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sop_core_side.sv
module sop_core_side #(
    parameter int DW      = 32,
    parameter int DV_ONE  = 2,
    parameter int DV_TWO  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] word_i,
    input  logic [DW-1:0] word_q,
    input  logic          dual_mode,
    input  logic          ack_sync,
    output logic          req_tgl,
    output logic [DW-1:0] buf_i,
    output logic [DW-1:0] buf_q,
    output logic          data_valid,
    output logic          overrun
);
    localparam int DVMAX = (DV_TWO > DV_ONE) ? DV_TWO : DV_ONE;
    localparam int DVW   = $clog2(DVMAX + 1);

    typedef struct packed {
        logic [DW-1:0]  bi;
        logic [DW-1:0]  bq;
        logic           req;
        logic           ack_seen;
        logic           pend;
        logic [DVW-1:0] dv_cnt;
        logic           dv;
        logic           ovr;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     ack_evt;

    always_comb begin
        st_d        = st_q;
        ack_evt     = (ack_sync != st_q.ack_seen);
        st_d.ack_seen = ack_sync;
        if (ack_evt) st_d.pend = 1'b0;
        if (load) begin
            st_d.bi     = word_i;
            st_d.bq     = word_q;
            st_d.req    = ~st_q.req;
            st_d.pend   = 1'b1;
            if (st_q.pend && !ack_evt) st_d.ovr = 1'b1;
            st_d.dv_cnt = dual_mode ? DVW'(DV_TWO) : DVW'(DV_ONE);
        end else if (st_q.dv_cnt != '0) begin
            st_d.dv_cnt = st_q.dv_cnt - 1'b1;
        end
        st_d.dv = (st_d.dv_cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl    = st_q.req;
    assign buf_i      = st_q.bi;
    assign buf_q      = st_q.bq;
    assign data_valid = st_q.dv;
    assign overrun    = st_q.ovr;

    // R3: a pulse that ends has lasted at least its minimum width
    a_r3_dv_width_single: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid) |-> ($past(data_valid, 2) && $past(data_valid, 1)));
    a_r3_dv_width_dual: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(data_valid) && dual_mode) |-> ($past(data_valid, 3) && $past(data_valid, 4)));
    // R3: a load always opens a pulse
    a_r3_dv_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> data_valid);
    // R10: overrun is sticky
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

// File: rtl/sop_ser_side.sv
module sop_ser_side #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic          dual_mode,
    input  logic [1:0]    len_sel,
    input  logic          req_sync,
    input  logic [DW-1:0] buf_i,
    input  logic [DW-1:0] buf_q,
    output logic          ack_tgl,
    output logic          sdata,
    output logic          frame_end,
    output logic          gap_err,
    output logic          underrun
);
    localparam int FW = 2 * DW;
    localparam int CW = $clog2(FW + 1);

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] hq;
        logic          hv;
        logic          req_seen;
        logic          ack;
        logic          active;
        logic [CW-1:0] cnt;
        logic [FW-1:0] shreg;
        logic          sd;
        logic          fend;
        logic          just_ended;
        logic          gap;
        logic          unr;
    } ser_st_t;

    ser_st_t       st_d, st_q;
    logic [CW-1:0] wbits, nbits;
    logic [FW-1:0] top_mask, frame_w;
    logic          new_word, start;

    always_comb begin
        wbits    = CW'(sop_pkg::word_len(len_sel, DW));
        nbits    = dual_mode ? (wbits << 1) : wbits;
        top_mask = ~({FW{1'b1}} >> wbits);
        frame_w  = {st_q.hi, {DW{1'b0}}} & top_mask;
        if (dual_mode)
            frame_w = frame_w | (({st_q.hq, {DW{1'b0}}} >> wbits) & (top_mask >> wbits));
    end

    always_comb begin
        st_d     = st_q;
        new_word = (req_sync != st_q.req_seen);
        start    = fsync && (!st_q.active || st_q.cnt == '0);
        st_d.just_ended = 1'b0;

        if (new_word) begin
            st_d.hi       = buf_i;
            st_d.hq       = buf_q;
            st_d.hv       = 1'b1;
            st_d.req_seen = req_sync;
        end

        if (start) begin
            if (st_q.just_ended) st_d.gap = 1'b1;
            if (st_q.hv) begin
                st_d.ack = ~st_q.ack;
                if (!new_word) st_d.hv = 1'b0;
                st_d.sd    = frame_w[FW-1];
                st_d.shreg = frame_w << 1;
            end else begin
                st_d.unr   = 1'b1;
                st_d.sd    = 1'b0;
                st_d.shreg = '0;
            end
            st_d.active = 1'b1;
            st_d.cnt    = nbits - 1'b1;
            st_d.fend   = (nbits == CW'(1));
        end else if (st_q.active && st_q.cnt != '0) begin
            st_d.sd    = st_q.shreg[FW-1];
            st_d.shreg = st_q.shreg << 1;
            st_d.cnt   = st_q.cnt - 1'b1;
            st_d.fend  = (st_q.cnt == CW'(1));
        end else if (st_q.active) begin
            st_d.active     = 1'b0;
            st_d.sd         = 1'b0;
            st_d.fend       = 1'b0;
            st_d.just_ended = 1'b1;
        end else begin
            st_d.sd   = 1'b0;
            st_d.fend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl   = st_q.ack;
    assign sdata     = st_q.sd;
    assign frame_end = st_q.fend;
    assign gap_err   = st_q.gap;
    assign underrun  = st_q.unr;

    // R2: a sync seen while idle opens a frame on the next edge
    a_r2_sync_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !st_q.active) |=> st_q.active);
    // R5: frame_end covers a single bit period
    a_r5_fend_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
    // R9: the line is quiet outside a frame
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !sdata);
    // R7: gap error is sticky
    a_r7_gap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        gap_err |=> gap_err);
    // R11: underrun is sticky
    a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/sop_serial_out.sv
module sop_serial_out #(
    parameter int DW        = 32,
    parameter int DV_ONE    = 2,
    parameter int DV_TWO    = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic          core_clk,
    input  logic          core_rst_n,
    input  logic          load,
    input  logic [DW-1:0] word_i,
    input  logic [DW-1:0] word_q,
    input  logic          dual_mode,
    input  logic [1:0]    len_sel,
    output logic          data_valid,
    output logic          overrun,
    input  logic          ser_clk,
    input  logic          ser_rst_n,
    input  logic          fsync_in,
    output logic          sdata_out,
    output logic          frame_end,
    output logic          gap_err,
    output logic          underrun
);
    logic          req_tgl, req_sync, ack_tgl, ack_sync;
    logic [DW-1:0] buf_i, buf_q;

    sop_core_side #(.DW(DW), .DV_ONE(DV_ONE), .DV_TWO(DV_TWO)) u_core (
        .clk(core_clk), .rst_n(core_rst_n), .load(load),
        .word_i(word_i), .word_q(word_q), .dual_mode(dual_mode),
        .ack_sync(ack_sync), .req_tgl(req_tgl),
        .buf_i(buf_i), .buf_q(buf_q),
        .data_valid(data_valid), .overrun(overrun)
    );

    sop_sync #(.STAGES(SYNC_STG)) u_req_sync (
        .clk(ser_clk), .rst_n(ser_rst_n), .d(req_tgl), .q(req_sync)
    );

    sop_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk(core_clk), .rst_n(core_rst_n), .d(ack_tgl), .q(ack_sync)
    );

    sop_ser_side #(.DW(DW)) u_ser (
        .clk(ser_clk), .rst_n(ser_rst_n), .fsync(fsync_in),
        .dual_mode(dual_mode), .len_sel(len_sel),
        .req_sync(req_sync), .buf_i(buf_i), .buf_q(buf_q),
        .ack_tgl(ack_tgl), .sdata(sdata_out), .frame_end(frame_end),
        .gap_err(gap_err), .underrun(underrun)
    );
endmodule

// File: tb/sim_sop_serial_out.sv
module sim_sop_serial_out;
    localparam int CORE_PER = 10;
    localparam int SER_PER  = 26;

    logic core_clk = 1'b0, ser_clk = 1'b0;
    logic core_rst_n = 1'b0, ser_rst_n = 1'b0;
    logic load0 = 1'b0, load1 = 1'b0;
    logic [31:0] wi0 = '0, wq0 = '0, wi1 = '0, wq1 = '0;
    logic dual = 1'b0;
    logic [1:0] lsel = 2'd0;
    logic fsync = 1'b0;
    logic dv0, ovr0, sd0, fe0, gap0, unr0;
    logic dv1, ovr1, sd1, fe1, gap1, unr1;
    logic line;
    int checks = 0, fails = 0;

    always #(CORE_PER/2) core_clk = ~core_clk;
    always #(SER_PER/2)  ser_clk  = ~ser_clk;
    assign line = sd0 | sd1;

    sop_serial_out u0 (
        .core_clk(core_clk), .core_rst_n(core_rst_n), .load(load0),
        .word_i(wi0), .word_q(wq0), .dual_mode(dual), .len_sel(lsel),
        .data_valid(dv0), .overrun(ovr0), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
        .fsync_in(fsync), .sdata_out(sd0), .frame_end(fe0),
        .gap_err(gap0), .underrun(unr0)
    );

    sop_serial_out u1 (
        .core_clk(core_clk), .core_rst_n(core_rst_n), .load(load1),
        .word_i(wi1), .word_q(wq1), .dual_mode(dual), .len_sel(lsel),
        .data_valid(dv1), .overrun(ovr1), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
        .fsync_in(fe0), .sdata_out(sd1), .frame_end(fe1),
        .gap_err(gap1), .underrun(unr1)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected frame, right-aligned, built bit by bit
    function automatic logic [63:0] want(input logic [31:0] i, input logic [31:0] q,
                                         input logic d, input int w);
        logic [63:0] e = '0;
        for (int b = 0; b < w; b++) e = {e[62:0], i[31-b]};
        if (d) for (int b = 0; b < w; b++) e = {e[62:0], q[31-b]};
        return e;
    endfunction

    task automatic do_reset();
        fsync = 1'b0; load0 = 1'b0; load1 = 1'b0;
        core_rst_n = 1'b0; ser_rst_n = 1'b0;
        repeat (4) @(negedge ser_clk);
        @(negedge core_clk); core_rst_n = 1'b1;
        @(negedge ser_clk);  ser_rst_n = 1'b1;
        repeat (2) @(negedge ser_clk);
    endtask

    task automatic do_load(input int which, input logic [31:0] i, input logic [31:0] q,
                           output int dvc);
        dvc = 0;
        @(negedge core_clk);
        if (which == 0) begin wi0 = i; wq0 = q; load0 = 1'b1; end
        else            begin wi1 = i; wq1 = q; load1 = 1'b1; end
        for (int k = 0; k < 8; k++) begin
            @(negedge core_clk);
            load0 = 1'b0; load1 = 1'b0;
            if ((which == 0 ? dv0 : dv1) === 1'b1) dvc++;
        end
        repeat (8) @(negedge ser_clk);
    endtask

    task automatic start_frame();
        @(negedge ser_clk); fsync = 1'b1;
    endtask

    task automatic shift_in(input int n, input int mid, input bit chain, input bit chk_fe,
                            output logic [63:0] bits);
        bits = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge ser_clk);
            fsync = (i == mid);
            bits = {bits[62:0], line};
            if (chk_fe) chk("R5 frame_end", 64'(fe0), 64'(i == n - 1));
            if (chain && i == n - 1) fsync = 1'b1;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sdata", 64'(sd0), 0);
        chk("R1 frame_end", 64'(fe0), 0);
        chk("R1 data_valid", 64'(dv0), 0);
        chk("R1 flags", {61'b0, ovr0, gap0, unr0}, 0);
    endtask

    task automatic t_single_lengths();
        logic [63:0] got;
        int dvc;
        dual = 1'b0;
        for (int s = 0; s < 4; s++) begin
            logic [31:0] a = 32'hA5C3_0000 ^ (32'h1357_9BDF * (s + 1));
            lsel = 2'(s);
            do_load(0, a, 32'hFFFF_FFFF, dvc);
            if (s == 0) chk("R3 dv width single", 64'(dvc), 2);
            start_frame();
            shift_in(8 * (s + 1), -1, 1'b0, 1'b1, got);
            chk("R2 single frame", got, want(a, 0, 1'b0, 8 * (s + 1)));
            @(negedge ser_clk);
            chk("R9 idle low", 64'(sd0), 0);
        end
    endtask

    task automatic t_dual();
        logic [63:0] got;
        int dvc;
        dual = 1'b1; lsel = 2'd1;
        do_load(0, 32'h8421_F00F, 32'h3C5A_0FF0, dvc);
        chk("R3 dv width dual", 64'(dvc), 4);
        start_frame();
        shift_in(32, -1, 1'b0, 1'b1, got);
        chk("R4 dual frame", got, want(32'h8421_F00F, 32'h3C5A_0FF0, 1'b1, 16));
        dual = 1'b0;
    endtask

    task automatic t_mid_sync();
        logic [63:0] got;
        int dvc;
        lsel = 2'd1;
        do_load(0, 32'hC0DE_1234, 0, dvc);
        start_frame();
        shift_in(16, 5, 1'b0, 1'b1, got);
        chk("R8 mid-frame sync ignored", got, want(32'hC0DE_1234, 0, 1'b0, 16));
        @(negedge ser_clk);
        chk("R8 no extra frame", 64'(sd0), 0);
    endtask

    task automatic t_back_to_back();
        logic [63:0] g1, g2;
        int dvc;
        lsel = 2'd3;
        do_load(0, 32'h1122_3344, 0, dvc);
        start_frame();
        fork
            shift_in(32, -1, 1'b1, 1'b1, g1);
            begin repeat (6) @(negedge ser_clk); do_load(0, 32'h99AA_BBCC, 0, dvc); end
        join
        shift_in(32, -1, 1'b0, 1'b1, g2);
        chk("R6 first frame", g1, want(32'h1122_3344, 0, 1'b0, 32));
        chk("R6 second frame no gap", g2, want(32'h99AA_BBCC, 0, 1'b0, 32));
        chk("R6 gap_err low", 64'(gap0), 0);
    endtask

    task automatic t_gaps();
        logic [63:0] got;
        int dvc;
        lsel = 2'd0;
        do_load(0, 32'h5A00_0000, 0, dvc);
        start_frame();
        shift_in(8, -1, 1'b0, 1'b0, got);
        do_load(0, 32'h3300_0000, 0, dvc);
        start_frame();
        shift_in(8, -1, 1'b0, 1'b0, got);
        chk("R7 long gap no error", 64'(gap0), 0);
        chk("R7 frame after long gap", got, want(32'h3300_0000, 0, 1'b0, 8));
        start_frame();
        fsync = 1'b1;
        @(negedge ser_clk); fsync = 1'b0;
        chk("R7 gap_err set", 64'(gap0), 1);
        do_reset();
        do_load(0, 32'hE100_0000, 0, dvc);
        start_frame();
        shift_in(8, -1, 1'b0, 1'b0, got);
        @(negedge ser_clk);
        start_frame();
        shift_in(8, -1, 1'b0, 1'b0, got);
        chk("R7 two-period gap no error", 64'(gap0), 0);
    endtask

    task automatic t_gap_one();
        logic [63:0] got;
        int dvc;
        do_reset();
        lsel = 2'd0;
        do_load(0, 32'h7700_0000, 0, dvc);
        start_frame();
        shift_in(8, -1, 1'b0, 1'b0, got);
        start_frame();
        shift_in(8, -1, 1'b0, 1'b0, got);
        chk("R7 one-period gap sets gap_err", 64'(gap0), 1);
        repeat (3) @(negedge ser_clk);
        chk("R7 gap_err sticky", 64'(gap0), 1);
    endtask

    task automatic t_overrun_underrun();
        logic [63:0] got;
        int dvc;
        do_reset();
        lsel = 2'd1;
        do_load(0, 32'h1111_0000, 0, dvc);
        chk("R10 no overrun after one load", 64'(ovr0), 0);
        do_load(0, 32'hBEEF_0000, 0, dvc);
        chk("R10 overrun set", 64'(ovr0), 1);
        start_frame();
        shift_in(16, -1, 1'b0, 1'b1, got);
        chk("R10 newer word sent", got, want(32'hBEEF_0000, 0, 1'b0, 16));
        chk("R11 no underrun yet", 64'(unr0), 0);
        repeat (3) @(negedge ser_clk);
        start_frame();
        shift_in(16, -1, 1'b0, 1'b1, got);
        chk("R11 zero frame", got, 0);
        chk("R11 underrun set", 64'(unr0), 1);
        chk("R10 overrun sticky", 64'(ovr0), 1);
    endtask

    task automatic t_cascade();
        logic [63:0] got;
        int dvc;
        do_reset();
        dual = 1'b0; lsel = 2'd1;
        do_load(0, 32'hD00D_0000, 0, dvc);
        do_load(1, 32'h4B1D_0000, 0, dvc);
        start_frame();
        shift_in(34, -1, 1'b0, 1'b0, got);
        chk("R12 cascaded readout", got,
            {30'b0, want(32'hD00D_0000, 0, 1'b0, 16)[15:0], want(32'h4B1D_0000, 0, 1'b0, 16)[15:0], 2'b00});
        chk("R12 second port no gap error", 64'(gap1), 0);
    endtask

    initial begin
        t_reset();
        t_single_lengths();
        t_dual();
        t_mid_sync();
        t_back_to_back();
        t_gaps();
        t_gap_one();
        t_overrun_underrun();
        t_cascade();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CORE_PER * 150000);
        checks++; fails++;
        $display("FAIL watchdog (R1..R12 run) actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule